// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

The block is a memory-mapped general-purpose I/O controller. Its pins are grouped into banks of 32, and each bank has its own register set. Software reads the synchronized pin levels, chooses for each pin whether it is an input or an output, and moves output levels through two separate registers: one sets bits and one clears bits. A read-modify-write of an output word is never needed.

Every pin has a rising-edge enable and a falling-edge enable. An edge that is enabled latches a status bit, and software clears that bit by writing one to it. A per-bank mask selects which status bits reach the interrupt outputs. One combined interrupt covers all pins, and the two lowest pins of bank 0 also drive interrupt lines of their own.

The register bus is a simple single-cycle interface: a write takes effect at the clock edge where select and write-enable are high, and read data is valid combinationally in the same cycle. The number of banks is a parameter.

Top module: `bgpio_ctrl`

## Requirements
- R1: After reset all direction, output, rising-enable, falling-enable and status bits are 0, every mask bit is 1, `pin_oe` and `pin_out` are 0, and all three interrupt outputs are low.
- R2: Bank n has base address ((n/3)*256) + ((n mod 3)*4). The register offsets from that base are:
  - level: 0x00
  - direction: 0x0C
  - output set: 0x18
  - output clear: 0x24
  - rising enable: 0x30
  - falling enable: 0x3C
  - status: 0x48
  - mask: 0x9C

  Reads of the set and clear registers, and reads of unmapped addresses, return 0.
- R3: Writing the set register drives high every output bit whose write bit is 1. Bits written as 0 keep their value.
- R4: Writing the clear register drives low every output bit whose write bit is 1. Bits written as 0 keep their value.
- R5: A direction bit of 1 makes that pin an output (`pin_oe` high). A direction bit of 0 makes it an input. The direction register reads back as written.
- R6: The level register returns the pin inputs after a two-flop synchronizer, so a pin change is readable two clock edges after it is sampled. Writes to the level register have no effect.
- R7: A rising edge on a pin with its rising enable set sets that pin's status bit. A rising edge on a pin whose rising enable is 0 does not.
- R8: A falling edge on a pin with its falling enable set sets that pin's status bit. A rising edge on a pin with only its falling enable set does not.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves the bit unchanged.
- R10: If an enabled edge is detected in the same cycle that software writes 1 to clear that status bit, the bit stays set.
- R11: `irq_any` is the OR, over all banks, of status AND mask. A status bit whose mask bit is 0 does not raise `irq_any`.
- R12: `irq_pin0` and `irq_pin1` equal bank 0 bits 0 and 1 of status AND mask, each independent of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| pin_in | input | NUM_BANKS*32 | Pin input levels (asynchronous) |
| pin_out | output | NUM_BANKS*32 | Output levels |
| pin_oe | output | NUM_BANKS*32 | Output enables (1 = drive) |
| irq_pin0 | output | 1 | Dedicated interrupt for pin 0 |
| irq_pin1 | output | 1 | Dedicated interrupt for pin 1 |
| irq_any | output | 1 | Combined interrupt for all pins |

## Verification
Assertions check every cycle that:
- a set or clear write lands on exactly the written bits;
- a direction write is taken as written;
- status bits never rise without a detected edge;
- an edge always survives a same-cycle clear;
- the interrupt outputs agree with each other and are quiet as reset is released.

Only the bench scenarios can show the address interleaving across a bank-group boundary, the two-cycle synchronizer latency seen through the level register, the gating of edges by their enables, and the exact cycle alignment in which a new edge and a clear write collide.

// File: rtl/bgpio_pkg.sv
package bgpio_pkg;

  localparam int BANK_W = 32;

  // Register offsets inside a bank
  localparam int OFF_LVL  = 'h00;
  localparam int OFF_DIR  = 'h0C;
  localparam int OFF_SET  = 'h18;
  localparam int OFF_CLR  = 'h24;
  localparam int OFF_RISE = 'h30;
  localparam int OFF_FALL = 'h3C;
  localparam int OFF_STAT = 'h48;
  localparam int OFF_MSK  = 'h9C;

  // Three banks share a 256-byte group, four bytes apart
  function automatic int bank_base(input int n);
    return ((n / 3) << 8) + ((n % 3) << 2);
  endfunction

endpackage

// File: rtl/bgpio_sync.sv
module bgpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
    end
  end

  assign dout = stab_q;

endmodule

// File: rtl/bgpio_bank.sv
module bgpio_bank
  import bgpio_pkg::*;
#(
  parameter int BANK_IDX = 0,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  input  logic [BANK_W-1:0] pin_sync,
  output logic [BANK_W-1:0] rd_data,
  output logic [BANK_W-1:0] out_q,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] irq_vec
);

  localparam int BASE = bank_base(BANK_IDX);
  localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(BASE + OFF_LVL);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(BASE + OFF_DIR);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(BASE + OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(BASE + OFF_CLR);
  localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(BASE + OFF_RISE);
  localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(BASE + OFF_FALL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE + OFF_STAT);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(BASE + OFF_MSK);

  logic wr, rd;
  logic wr_dir, wr_set, wr_clr, wr_rise, wr_fall, wr_stat, wr_msk;

  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] rise_q, fall_q, st_q, msk_q;
  logic [BANK_W-1:0] out_d, dir_d, rise_d, fall_d, st_d, msk_d;
  logic              out_en, st_en;
  logic [BANK_W-1:0] evt, st_clr;

  // Decode
  assign wr      = bus_sel & bus_we;
  assign rd      = bus_sel & ~bus_we;
  assign wr_dir  = wr & (bus_addr == A_DIR);
  assign wr_set  = wr & (bus_addr == A_SET);
  assign wr_clr  = wr & (bus_addr == A_CLR);
  assign wr_rise = wr & (bus_addr == A_RISE);
  assign wr_fall = wr & (bus_addr == A_FALL);
  assign wr_stat = wr & (bus_addr == A_STAT);
  assign wr_msk  = wr & (bus_addr == A_MSK);

  // Edge detect against the previous synchronized sample
  assign evt = (pin_sync & ~prev_q & rise_q) | (~pin_sync & prev_q & fall_q);

  // Next-state logic
  always_comb begin
    out_d = out_q;
    if (wr_set) out_d = out_q | bus_wdata;
    if (wr_clr) out_d = out_q & ~bus_wdata;
    out_en = wr_set | wr_clr;

    dir_d  = bus_wdata;
    rise_d = bus_wdata;
    fall_d = bus_wdata;
    msk_d  = bus_wdata;

    st_clr = wr_stat ? bus_wdata : '0;
    st_d   = (st_q & ~st_clr) | evt;
    st_en  = wr_stat | (|evt);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      out_q  <= '0;
      dir_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      st_q   <= '0;
      msk_q  <= '1;
    end else begin
      prev_q <= pin_sync;
      if (out_en)  out_q  <= out_d;
      if (wr_dir)  dir_q  <= dir_d;
      if (wr_rise) rise_q <= rise_d;
      if (wr_fall) fall_q <= fall_d;
      if (st_en)   st_q   <= st_d;
      if (wr_msk)  msk_q  <= msk_d;
    end
  end

  // Read mux; set/clear and unmapped addresses read 0
  always_comb begin
    rd_data = '0;
    if (rd) begin
      if      (bus_addr == A_LVL)  rd_data = pin_sync;
      else if (bus_addr == A_DIR)  rd_data = dir_q;
      else if (bus_addr == A_RISE) rd_data = rise_q;
      else if (bus_addr == A_FALL) rd_data = fall_q;
      else if (bus_addr == A_STAT) rd_data = st_q;
      else if (bus_addr == A_MSK)  rd_data = msk_q;
      else                         rd_data = '0;
    end
  end

  assign irq_vec = st_q & msk_q;

  // R3: written ones are high afterwards
  a_r3_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((out_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R4: written ones are low afterwards
  a_r4_clear_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((out_q & $past(bus_wdata)) == '0));

  // R5: direction register takes written word
  a_r5_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (dir_q == $past(bus_wdata)));

  // R9: a one-write clears bits with no competing edge
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((st_q & $past(bus_wdata & ~evt)) == '0));

  // R10: a detected edge is always latched, even against a clear
  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((st_q & $past(evt)) == $past(evt)));

  // R7: status never rises without an enabled edge
  a_r7_no_spurious_status: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0) |=> ((st_q & ~$past(st_q)) == '0));

endmodule

// File: rtl/bgpio_ctrl.sv
module bgpio_ctrl
  import bgpio_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
  output logic [NUM_BANKS*BANK_W-1:0] pin_out,
  output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
  output logic                        irq_pin0,
  output logic                        irq_pin1,
  output logic                        irq_any
);

  localparam int PIN_W = NUM_BANKS * BANK_W;

  // Reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_ff;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_int_n = rst_ff[1];

  logic [PIN_W-1:0] pin_s;
  logic [PIN_W-1:0] irq_all;
  logic [BANK_W-1:0] rd_bank [NUM_BANKS];

  bgpio_sync #(.W(PIN_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (pin_in),
    .dout  (pin_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bgpio_bank #(
      .BANK_IDX (b),
      .ADDR_W   (ADDR_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .pin_sync  (pin_s[b*BANK_W +: BANK_W]),
      .rd_data   (rd_bank[b]),
      .out_q     (pin_out[b*BANK_W +: BANK_W]),
      .dir_q     (pin_oe[b*BANK_W +: BANK_W]),
      .irq_vec   (irq_all[b*BANK_W +: BANK_W])
    );
  end

  // At most one bank decodes an address, so OR merges reads
  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) bus_rdata = bus_rdata | rd_bank[b];
  end

  assign irq_any  = |irq_all;
  assign irq_pin0 = irq_all[0];
  assign irq_pin1 = irq_all[1];

  // R12: a dedicated line is never active without the combined one
  a_r12_dedicated_implies_any: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_pin0 || irq_pin1) |-> irq_any);

  // R1: outputs quiet in the first cycle after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (pin_oe == '0 && pin_out == '0 && !irq_any));

endmodule

// File: tb/bgpio_ctrl_tb.sv
module bgpio_ctrl_tb_top;

  localparam int NB = 4;
  localparam int AW = 12;

  logic              clk;
  logic              rst_n;
  logic              bus_sel, bus_we;
  logic [AW-1:0]     bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic [NB*32-1:0]  pins, pin_out, pin_oe;
  logic              irq_pin0, irq_pin1, irq_any;

  int n_chk = 0;
  int n_fail = 0;

  bgpio_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pins),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_pin0  (irq_pin0),
    .irq_pin1  (irq_pin1),
    .irq_any   (irq_any)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [AW-1:0] addr_of(input int bank, input int off);
    return AW'(((bank / 3) << 8) + ((bank % 3) << 2) + off);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(addr_of(0, 'h9C), d); chk("R1 mask reset", d, 32'hFFFF_FFFF);
    rd(addr_of(2, 'h0C), d); chk("R1 dir reset", d, 32'h0);
    rd(addr_of(1, 'h48), d); chk("R1 status reset", d, 32'h0);
    chk("R1 pin_oe reset", pin_oe[31:0] | pin_oe[127:96], 32'h0);
    chk("R1 irqs reset", {29'h0, irq_pin0, irq_pin1, irq_any}, 32'h0);
  endtask

  task automatic t_set_clear;
    logic [31:0] d;
    wr(addr_of(1, 'h18), 32'h0000_00F0);
    chk("R3 set bank1", pin_out[32 +: 32], 32'h0000_00F0);
    wr(addr_of(1, 'h18), 32'h0000_0001);
    chk("R3 set keeps others", pin_out[32 +: 32], 32'h0000_00F1);
    wr(addr_of(1, 'h24), 32'h0000_0030);
    chk("R4 clear bank1", pin_out[32 +: 32], 32'h0000_00C1);
    chk("R2 other bank untouched", pin_out[31:0], 32'h0);
    rd(addr_of(1, 'h18), d); chk("R2 set reads zero", d, 32'h0);
  endtask

  task automatic t_dir;
    logic [31:0] d;
    wr(addr_of(3, 'h0C), 32'h0000_A5A5);
    chk("R5 pin_oe bank3", pin_oe[96 +: 32], 32'h0000_A5A5);
    rd(12'h10C, d); chk("R2 R5 bank3 dir at 0x10C", d, 32'h0000_A5A5);
    chk("R5 bank0 still input", pin_oe[31:0], 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    @(negedge clk); pins[64 +: 32] = 32'h1234_5678;
    wait_cyc(3);
    rd(12'h008, d); chk("R6 level bank2", d, 32'h1234_5678);
    wr(12'h008, 32'hFFFF_0000);
    rd(12'h008, d); chk("R6 level write ignored", d, 32'h1234_5678);
  endtask

  task automatic t_pin_irq;
    logic [31:0] d;
    wr(addr_of(0, 'h30), 32'h3);
    @(negedge clk); pins[0] = 1'b1;
    wait_cyc(4);
    chk("R12 pin0 line", {30'h0, irq_pin1, irq_pin0}, 32'h1);
    chk("R11 any follows pin0", {31'h0, irq_any}, 32'h1);
    wr(addr_of(0, 'h48), 32'h1);
    chk("R9 R12 pin0 cleared", {31'h0, irq_pin0}, 32'h0);
    @(negedge clk); pins[1] = 1'b1;
    wait_cyc(4);
    chk("R12 pin1 line", {30'h0, irq_pin1, irq_pin0}, 32'h2);
    wr(addr_of(0, 'h48), 32'h2);
    wr(addr_of(0, 'h30), 32'h0);
    rd(addr_of(0, 'h48), d); chk("R9 status clean", d, 32'h0);
  endtask

  task automatic t_rise_mask;
    logic [31:0] d;
    wr(addr_of(0, 'h30), 32'h20);
    @(negedge clk); pins[5] = 1'b1; pins[6] = 1'b1;
    wait_cyc(4);
    rd(addr_of(0, 'h48), d); chk("R7 only enabled rise", d, 32'h20);
    chk("R11 any high", {31'h0, irq_any}, 32'h1);
    wr(addr_of(0, 'h9C), ~32'h20);
    chk("R11 masked status", {31'h0, irq_any}, 32'h0);
    wr(addr_of(0, 'h9C), 32'hFFFF_FFFF);
    wr(addr_of(0, 'h48), 32'h0);
    rd(addr_of(0, 'h48), d); chk("R9 zero write no effect", d, 32'h20);
    wr(addr_of(0, 'h48), 32'h20);
    rd(addr_of(0, 'h48), d); chk("R9 one write clears", d, 32'h0);
  endtask

  task automatic t_fall;
    logic [31:0] d;
    wr(12'h13C, 32'h1);
    @(negedge clk); pins[96] = 1'b1;
    wait_cyc(4);
    rd(12'h148, d); chk("R8 rise ignored with fall enable", d, 32'h0);
    @(negedge clk); pins[96] = 1'b0;
    wait_cyc(4);
    rd(12'h148, d); chk("R8 fall captured bank3", d, 32'h1);
    chk("R11 any from bank3", {31'h0, irq_any}, 32'h1);
    wr(12'h148, 32'h1);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    @(negedge clk); pins[5] = 1'b0;
    wait_cyc(4);
    rd(addr_of(0, 'h48), d); chk("R10 precondition clean", d, 32'h0);
    @(negedge clk); pins[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = addr_of(0, 'h48); bus_wdata = 32'h20;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    rd(addr_of(0, 'h48), d); chk("R10 edge beats clear", d, 32'h20);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(12'h0FC, d); chk("R2 unmapped reads zero", d, 32'h0);
    rd(addr_of(2, 'h24), d); chk("R2 clear reads zero", d, 32'h0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pins = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset;
    t_set_clear;
    t_dir;
    t_level;
    t_pin_irq;
    t_rise_mask;
    t_fall;
    t_collide;
    t_unmapped;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

endmodule